// File: doc/BRIEF.md
# Global Drift Calibration Unit

This block keeps matrix-vector product results consistent while the conductances of a resistive crossbar drift uniformly over time. Right after the array is programmed, a capture command sweeps a configured window of cells. The cells are read one at a time, each returning an 8-bit code, and the sum of the codes is kept as the reference. Each later calibration trigger is issued at the first inner iteration of every outer refinement pass. It sweeps the same window and divides the reference sum by the new sum in a sequential divider. The result is one global correction factor with 16 fractional bits.

The factor scales every product result that passes through the unit. No drift law is assumed and no cell gets its own correction: the only input is the two measured sums. While a sweep or a division is running, the product stream is held off through its valid/ready handshake. Two flags are provided. One reports a calibration attempted before any reference exists. The other reports a zero current sum, in which case the old factor is kept.

Top module: `drift_cal_unit`

## Requirements
- R1: After reset the factor output is 1.0 (0x10000, unsigned with 16 fractional bits), both flags are low, busy is low and no read is requested.
- R2: A capture reads the cells at addresses base, base+1, ..., base+count-1, taken modulo 256. It reads them in ascending order, each exactly once, with one request outstanding at a time. It stores their sum as the reference, sets the factor to 1.0 and clears the no-reference flag. A count of 0 reads nothing.
- R3: A calibration makes the same sweep and then sets the factor to floor(reference * 65536 / current_sum).
- R4: A calibration trigger given before any capture sets the no-reference flag, issues no read and leaves the factor unchanged.
- R5: If the current sum is zero, the factor keeps its previous value and the zero-sum flag is set. The flag is cleared by the next calibration that updates the factor.
- R6: Each product, a signed 16-bit two's-complement value p, leaves as min(32767, max(-32768, floor((p*factor + 32768) / 65536))).
- R7: While busy, prod_ready_o is low. While out_valid_o is high and out_ready_i is low, the output holds its value.
- R8: Capture and calibration triggers that arrive while busy are ignored. If both arrive together while idle, capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| capture_i | input | 1 | Sweep the window and store the sum as the reference |
| cal_start_i | input | 1 | Sweep the window and recompute the factor |
| cfg_base_i | input | 8 | First cell address of the window, latched at the trigger |
| cfg_count_i | input | 8 | Number of cells in the window, latched at the trigger |
| rd_req_o | output | 1 | Cell read request |
| rd_addr_o | output | 8 | Cell address of the request |
| rd_ack_i | input | 1 | Read response; data is accepted in this cycle |
| rd_data_i | input | 8 | Cell code returned with the response |
| prod_valid_i | input | 1 | Product input valid |
| prod_ready_o | output | 1 | Product input ready |
| prod_data_i | input | 16 | Signed product input |
| out_valid_o | output | 1 | Scaled product valid |
| out_ready_i | input | 1 | Scaled product accepted |
| out_data_o | output | 16 | Signed scaled product |
| factor_o | output | 32 | Correction factor, 16 fractional bits |
| busy_o | output | 1 | Sweep or division in progress |
| err_noref_o | output | 1 | Calibration attempted with no reference |
| fault_zero_o | output | 1 | Last calibration saw a zero sum |

## Verification
The bench runs calibrations at drift levels that pull the factor both below and above 1.0. It uses windows of one cell, a few cells, and 255 cells that wrap past address 255. A wrong address sequence or wrap would show up as a sum mismatch and a misordered read. A product sweep across the whole signed range, with a factor near 2, exercises rounding and both saturation rails; wrong rounding or a wrapped overflow would give off-by-one or sign-flipped outputs. The bench also covers a zero sum, a trigger before any capture, triggers while busy, and a stalled output port. A design that divided by zero, swept without a reference, or let products through mid-calibration would change the factor or the stream at those points.

// File: rtl/drift_cal_pkg.sv
package drift_cal_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SWEEP, ST_DIV} cal_state_e;
endpackage

// File: rtl/dc_sweep.sv
module dc_sweep #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int CODE_W = 8,
  localparam int SUM_W = CODE_W + CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [CODE_W-1:0] rd_data_i,
  output logic              done_o,
  output logic [SUM_W-1:0]  sum_o
);
  logic             run_q;
  logic [CNT_W-1:0] left_q;

  assign rd_req_o = run_q && (left_q != '0);
  assign done_o   = run_q && (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      left_q    <= '0;
      rd_addr_o <= '0;
      sum_o     <= '0;
    end else if (start_i) begin
      run_q     <= 1'b1;
      left_q    <= count_i;
      rd_addr_o <= base_i;
      sum_o     <= '0;
    end else if (done_o) begin
      run_q <= 1'b0;
    end else if (rd_req_o && rd_ack_i) begin
      sum_o     <= sum_o + SUM_W'(rd_data_i);
      left_q    <= left_q - 1'b1;
      rd_addr_o <= rd_addr_o + 1'b1;
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i && !start_i |=> rd_req_o && $stable(rd_addr_o));
  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i && !start_i |=> rd_addr_o == $past(rd_addr_o) + 1'b1);
endmodule

// File: rtl/dc_divider.sv
module dc_divider #(
  parameter int SUM_W = 16,
  parameter int FRAC  = 16,
  localparam int NUM_W = SUM_W + FRAC,
  localparam int CW    = $clog2(NUM_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SUM_W-1:0] num_i,
  input  logic [SUM_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  logic [SUM_W-1:0] rem_q, den_q;
  logic [SUM_W:0]   rem_sh;
  logic [CW-1:0]    cnt_q;
  logic             run_q;

  assign rem_sh = {rem_q, quot_o[NUM_W-1]};
  assign done_o = run_q && (cnt_q == CW'(NUM_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quot_o <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      den_q  <= den_i;
      quot_o <= {num_i, {FRAC{1'b0}}};
      cnt_q  <= '0;
      run_q  <= 1'b1;
    end else if (done_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (rem_sh >= {1'b0, den_q}) begin
        rem_q  <= SUM_W'(rem_sh - {1'b0, den_q});
        quot_o <= {quot_o[NUM_W-2:0], 1'b1};
      end else begin
        rem_q  <= rem_sh[SUM_W-1:0];
        quot_o <= {quot_o[NUM_W-2:0], 1'b0};
      end
    end
  end

  assert_nonzero_den_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> den_i != '0);
  assert_rem_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> rem_q < den_q);
endmodule

// File: rtl/dc_scaler.sv
module dc_scaler #(
  parameter int DATA_W = 16,
  parameter int FACT_W = 32,
  parameter int FRAC   = 16,
  localparam int MUL_W = DATA_W + FACT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [FACT_W-1:0] factor_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);
  localparam logic signed [MUL_W-1:0] MAXV = MUL_W'((1 << (DATA_W-1)) - 1);
  localparam logic signed [MUL_W-1:0] MINV = -MUL_W'(1 << (DATA_W-1));

  logic signed [MUL_W-1:0] prod, rnd;
  logic [DATA_W-1:0]       sat;

  assign prod = MUL_W'($signed(in_data_i)) * $signed({1'b0, factor_i});
  assign rnd  = (prod + MUL_W'(1 << (FRAC-1))) >>> FRAC;
  always_comb begin
    if (rnd > MAXV)      sat = DATA_W'(MAXV);
    else if (rnd < MINV) sat = DATA_W'(MINV);
    else                 sat = rnd[DATA_W-1:0];
  end

  assign in_ready_o = enable_i && (!out_valid_o || out_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (in_valid_i && in_ready_o) begin
      out_valid_o <= 1'b1;
      out_data_o  <= sat;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
endmodule

// File: rtl/drift_cal_unit.sv
module drift_cal_unit
  import drift_cal_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int CODE_W = 8,
  parameter int DATA_W = 16,
  parameter int FRAC   = 16,
  localparam int SUM_W  = CODE_W + CNT_W,
  localparam int FACT_W = SUM_W + FRAC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              cal_start_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [CODE_W-1:0] rd_data_i,
  input  logic              prod_valid_i,
  output logic              prod_ready_o,
  input  logic [DATA_W-1:0] prod_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [FACT_W-1:0] factor_o,
  output logic              busy_o,
  output logic              err_noref_o,
  output logic              fault_zero_o
);
  localparam logic [FACT_W-1:0] ONE = FACT_W'(1) << FRAC;

  cal_state_e       state_q;
  logic             mode_cap_q, have_ref_q;
  logic [SUM_W-1:0] ref_q, sum;
  logic             sweep_start, sweep_done, div_start, div_done;
  logic [FACT_W-1:0] quot;

  assign busy_o      = (state_q != ST_IDLE);
  assign sweep_start = (state_q == ST_IDLE) && (capture_i || (cal_start_i && have_ref_q));
  assign div_start   = (state_q == ST_SWEEP) && sweep_done && !mode_cap_q && (sum != '0);

  dc_sweep #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CODE_W(CODE_W)) i_sweep (
    .clk_i, .rst_ni, .start_i(sweep_start), .base_i(cfg_base_i), .count_i(cfg_count_i),
    .rd_req_o, .rd_addr_o, .rd_ack_i, .rd_data_i, .done_o(sweep_done), .sum_o(sum));

  dc_divider #(.SUM_W(SUM_W), .FRAC(FRAC)) i_div (
    .clk_i, .rst_ni, .start_i(div_start), .num_i(ref_q), .den_i(sum),
    .done_o(div_done), .quot_o(quot));

  dc_scaler #(.DATA_W(DATA_W), .FACT_W(FACT_W), .FRAC(FRAC)) i_scale (
    .clk_i, .rst_ni, .enable_i(!busy_o), .factor_i(factor_o),
    .in_valid_i(prod_valid_i), .in_ready_o(prod_ready_o), .in_data_i(prod_data_i),
    .out_valid_o, .out_ready_i, .out_data_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      mode_cap_q   <= 1'b0;
      have_ref_q   <= 1'b0;
      ref_q        <= '0;
      factor_o     <= ONE;
      err_noref_o  <= 1'b0;
      fault_zero_o <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (sweep_start) begin
            mode_cap_q <= capture_i;
            state_q    <= ST_SWEEP;
          end else if (cal_start_i) begin
            err_noref_o <= 1'b1;
          end
        end
        ST_SWEEP: begin
          if (sweep_done) begin
            if (mode_cap_q) begin
              ref_q       <= sum;
              have_ref_q  <= 1'b1;
              factor_o    <= ONE;
              err_noref_o <= 1'b0;
              state_q     <= ST_IDLE;
            end else if (sum == '0) begin
              fault_zero_o <= 1'b1;
              state_q      <= ST_IDLE;
            end else begin
              state_q <= ST_DIV;
            end
          end
        end
        ST_DIV: begin
          if (div_done) begin
            factor_o     <= quot;
            fault_zero_o <= 1'b0;
            state_q      <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !prod_ready_o);
  assert_idle_noreq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o);
  assert_zero_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_zero_o) |-> $stable(factor_o));
  assert_busy_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIV) && !div_done |=> state_q == ST_DIV);
endmodule

// File: tb/test_drift_cal_unit.sv
module test_drift_cal_unit;
  logic clk = 0, rst_n = 0;
  logic capture = 0, cal = 0;
  logic [7:0] base = 0, count = 0;
  logic rd_req, rd_ack = 0;
  logic [7:0] rd_addr, rd_data = 0;
  logic pv = 0, pr, ov, ordy = 1;
  logic [15:0] pd = 0, od;
  logic [31:0] factor;
  logic busy, err_nr, fz;

  int total = 0, bad = 0;
  int scale = 8;
  int nreads = 0;
  logic [7:0] exp_addr = 0;
  bit order_ok = 1;

  always #5 clk = ~clk;

  drift_cal_unit i_drift_cal_unit (
    .clk_i(clk), .rst_ni(rst_n), .capture_i(capture), .cal_start_i(cal),
    .cfg_base_i(base), .cfg_count_i(count), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_ack_i(rd_ack), .rd_data_i(rd_data), .prod_valid_i(pv), .prod_ready_o(pr),
    .prod_data_i(pd), .out_valid_o(ov), .out_ready_i(ordy), .out_data_o(od),
    .factor_o(factor), .busy_o(busy), .err_noref_o(err_nr), .fault_zero_o(fz));

  function automatic int cellv(int a, int s);
    return (((a * 37 + 11) % 200) + 20) * s / 8;
  endfunction

  function automatic longint win_sum(int b, int c, int s);
    longint t = 0;
    for (int i = 0; i < c; i++) t += cellv((b + i) % 256, s);
    return t;
  endfunction

  always @(negedge clk) begin
    if (rd_req && !rd_ack) begin
      rd_ack  <= 1;
      rd_data <= 8'(cellv(rd_addr, scale));
      if (rd_addr != exp_addr) order_ok = 0;
      exp_addr <= rd_addr + 8'd1;
      nreads++;
    end else rd_ack <= 0;
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic trig(bit is_cap, int b, int c);
    @(negedge clk);
    base = 8'(b); count = 8'(c); exp_addr = 8'(b); nreads = 0; order_ok = 1;
    if (is_cap) capture = 1; else cal = 1;
    @(negedge clk);
    capture = 0; cal = 0;
    while (busy) begin
      chk(pr == 0, "R7 stall", pr, 0);
      @(negedge clk);
    end
  endtask

  function automatic longint scaled(longint p, longint f);
    longint q = (p * f + 32768) >>> 16;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic send(int p);
    @(negedge clk);
    pv = 1; pd = 16'(p);
    while (!pr) @(negedge clk);
    @(negedge clk);
    pv = 0;
    chk(ov && $signed(od) == scaled(p, factor), "R6 scale", $signed(od), scaled(p, factor));
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint r, c, f;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(factor == 32'h10000 && !busy && !err_nr && !fz && !rd_req, "R1 reset", factor, 32'h10000);

    // R4: calibrate before any capture
    trig(0, 5, 4);
    chk(err_nr == 1, "R4 flag", err_nr, 1);
    chk(nreads == 0, "R4 no reads", nreads, 0);
    chk(factor == 32'h10000, "R4 factor", factor, 32'h10000);

    // R2: capture, scale 8
    scale = 8;
    trig(1, 10, 8);
    r = win_sum(10, 8, 8);
    chk(nreads == 8 && order_ok, "R2 sweep", nreads, 8);
    chk(factor == 32'h10000 && !err_nr, "R2 factor one", factor, 32'h10000);

    // R3: drift down across several levels
    for (int s = 7; s >= 4; s--) begin
      scale = s;
      trig(0, 10, 8);
      c = win_sum(10, 8, s);
      f = (r * 65536) / c;
      chk(nreads == 8 && order_ok, "R3 sweep", nreads, 8);
      chk(factor == f && !fz, "R3 factor", factor, f);
    end

    // R6: full product sweep with factor near 2
    for (int p = -32768; p < 32768; p += 257) send(p);
    send(32767); send(-32768); send(0); send(1); send(-1);

    // R7: output hold while downstream stalls
    @(negedge clk);
    ordy = 0; pv = 1; pd = 16'd1000;
    @(negedge clk);
    pv = 0;
    f = scaled(1000, factor);
    repeat (4) begin
      @(negedge clk);
      chk(ov && $signed(od) == f && !pr, "R7 hold", $signed(od), f);
    end
    ordy = 1;
    @(negedge clk);
    chk(!ov, "R7 drain", ov, 0);

    // R8: triggers while busy ignored; capture wins over cal
    f = factor;
    @(negedge clk);
    base = 10; count = 8; nreads = 0; exp_addr = 10; order_ok = 1;
    capture = 1; cal = 1;
    @(negedge clk);
    capture = 0; cal = 0;
    @(negedge clk);
    cal = 1; capture = 1; base = 100;
    @(negedge clk);
    cal = 0; capture = 0;
    while (busy) @(negedge clk);
    chk(nreads == 8 && order_ok, "R8 busy ignore", nreads, 8);
    chk(factor == 32'h10000, "R8 capture wins", factor, 32'h10000);
    r = win_sum(10, 8, 4);

    // R3: wrapping 255-cell window, drift up
    scale = 4;
    trig(1, 200, 255);
    r = win_sum(200, 255, 4);
    chk(nreads == 255 && order_ok, "R2 wrap sweep", nreads, 255);
    scale = 8;
    trig(0, 200, 255);
    f = (r * 65536) / win_sum(200, 255, 8);
    chk(factor == f, "R3 wrap factor", factor, f);

    // R3: single cell
    trig(0, 7, 1);
    f = (r * 65536) / cellv(7, 8);
    chk(nreads == 1 && factor == f, "R3 one cell", factor, f);

    // R5: zero sum via empty window, then via zero cells
    f = factor;
    trig(0, 7, 0);
    chk(fz && factor == f && nreads == 0, "R5 empty", factor, f);
    scale = 0;
    trig(0, 30, 6);
    chk(fz && factor == f, "R5 zero cells", factor, f);
    send(5000);
    scale = 8;
    trig(0, 30, 6);
    c = (r * 65536) / win_sum(30, 6, 8);
    chk(!fz && factor == c, "R5 recover", factor, c);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule